// File: doc/BRIEF.md
# Double-Buffered Synchronous Serial Transmitter

This block serializes characters written by a processor onto a single data line, with an accompanying serial clock. A byte write lands in a one-entry holding buffer. At the next rising serial-clock edge where the shifter is free, the byte moves into a shift register, which frames it and sends it one bit per rising serial-clock edge. While that character is on the line, software may write the next byte. That byte follows the last stop bit with no idle gap.

A frame is one or two start bits (0), then 7, 8 or 9 data bits sent least significant bit first, then an optional parity bit, then one or two stop bits (1). In 9-bit format the ninth bit comes from a separate control input, used for multiprocessor address marking, and parity is never sent. The serial clock is either taken from an external input or produced by an internal divider of the system clock. In the internal case, the divider's clock is driven out with its output enable high.

The core is a five-state machine. The states are IDLE, START, DATA, PARITY and STOP, and each transition happens on a serial-clock tick. The transitions are:
- IDLE→START: the buffer is full (load).
- START→START: a second start bit is selected.
- START→DATA: the last start bit has been sent.
- DATA→DATA: more data bits remain.
- DATA→PARITY: parity is on.
- DATA→STOP: parity is off.
- PARITY→STOP: the parity bit has been sent.
- STOP→STOP: a second stop bit is selected.
- STOP→START: the last stop bit has been sent and the buffer is full (reload).
- STOP→IDLE: the last stop bit has been sent and the buffer is empty.

Top module: `sstx_top`

## Requirements
- R1: A pulse on `wr_en` stores `wr_data` in the holding buffer. At the first serial-clock tick where the state machine is in IDLE, or has just finished its last stop bit, the buffer moves into the shift register. The format inputs (`fmt_sel`, `par_en`, `par_odd`, `two_start`, `two_stop`, `bit9`) are sampled at that move.
- R2: The data line changes only on serial-clock ticks, one frame bit per tick, with data bits least significant first.
- R3: A byte written while a frame is shifting is sent directly after that frame's last stop bit, with no idle bit between the two frames.
- R4: `tx_empty` rises in the cycle the holding buffer moves into the shift register, and `tx_busy` is high in that cycle.
- R5: `tx_empty` is low in the cycle after any write.
- R6: `tx_busy` goes high when a frame is loaded. It stays high across back-to-back frames and falls only after the last stop bit when the buffer is empty.
- R7: `fmt_sel` = 2 or 3 selects 9-bit format. The ninth bit sent equals `bit9`, and no parity bit is sent even when `par_en` = 1.
- R8: `fmt_sel` = 0 sends `wr_data[6:0]` and `fmt_sel` = 1 sends `wr_data[7:0]`. With `par_en` = 1, a parity bit follows the last data bit.
- R9: `par_odd` = 0 makes the parity bit give an even count of ones over the data bits and parity. `par_odd` = 1 gives an odd count.
- R10: `two_start` = 1 sends two start bits instead of one, and `two_stop` = 1 sends two stop bits instead of one.
- R11: The line rests at 1 whenever `tx_busy` is low. A start bit is 0 and a stop bit is 1.
- R12: With `use_int` = 1 the serial clock is the internal divider output. That clock toggles every `div_val`+1 system cycles, appears on `sclk_out`, and `sclk_oe` = 1. With `use_int` = 0, rising edges of `sclk_in` clock the transmitter and `sclk_oe` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Byte to send |
| bit9 | input | 1 | Ninth data bit in 9-bit format |
| fmt_sel | input | 2 | 0: 7 data bits, 1: 8 data bits, 2 or 3: 9 data bits |
| par_en | input | 1 | Parity bit enable (7/8-bit formats only) |
| par_odd | input | 1 | 0 even parity, 1 odd parity |
| two_start | input | 1 | Two start bits when 1 |
| two_stop | input | 1 | Two stop bits when 1 |
| use_int | input | 1 | Select internal divider clock |
| div_val | input | DIV_W | Divider half-period minus one, in system cycles |
| sclk_in | input | 1 | External serial clock |
| sclk_out | output | 1 | Internal serial clock drive |
| sclk_oe | output | 1 | Output enable for `sclk_out` |
| txd | output | 1 | Serial data line |
| tx_empty | output | 1 | Holding buffer empty |
| tx_busy | output | 1 | Transmission in progress |

## Verification
The assertions assume that the format inputs stay stable from a write until the byte loads. They also assume that `use_int` and `div_val` change only while the transmitter is idle with an empty buffer. The one assertion that tolerates a write in the same cycle that `tx_busy` falls reflects that a write may arrive at any time. The bench changes the format and clock selection only between frames, after the line has returned to idle. It writes a second byte only once the first has been loaded, so no pending byte is ever overwritten.

// File: rtl/sstx_pkg.sv
package sstx_pkg;
    localparam int SHIFT_W = 9;
    localparam int CNT_W   = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_t;

    function automatic logic [CNT_W-1:0] data_len(input logic [1:0] fmt);
        unique case (fmt)
            2'd0:    data_len = CNT_W'(7);
            2'd1:    data_len = CNT_W'(8);
            default: data_len = CNT_W'(9);
        endcase
    endfunction
endpackage

// File: rtl/sstx_baud.sv
module sstx_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] half_div,
    output logic             sclk,
    output logic             rise
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            sclk <= 1'b0;
            rise <= 1'b0;
        end else begin
            rise <= 1'b0;
            if (cnt >= half_div) begin
                cnt  <= '0;
                sclk <= ~sclk;
                rise <= ~sclk;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sstx_sync_edge.sv
module sstx_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-1:0], async_in};
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/sstx_frame.sv
module sstx_frame
    import sstx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       bit9,
    input  logic [1:0] fmt_sel,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       two_start,
    input  logic       two_stop,
    output logic       txd,
    output logic       tx_empty,
    output logic       tx_busy
);
    tx_state_t          state, state_n;
    logic [7:0]         hold_q;
    logic               hold_full;
    logic [SHIFT_W-1:0] shreg;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   len_q;
    logic               par_q, par_use_q, stop2_q;

    logic               last_cnt, load;
    logic [SHIFT_W-1:0] load_vec;
    logic               par_calc;

    // Data as it enters the shift register, masked to the chosen width
    always_comb begin
        unique case (fmt_sel)
            2'd0:    load_vec = {2'b00, hold_q[6:0]};
            2'd1:    load_vec = {1'b0, hold_q};
            default: load_vec = {bit9, hold_q};
        endcase
        par_calc = (^load_vec) ^ par_odd;
    end

    assign last_cnt = (cnt == '0);
    assign load     = tick && hold_full &&
                      ((state == ST_IDLE) || ((state == ST_STOP) && last_cnt));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Transitions
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:   if (load) state_n = ST_START;
            ST_START:  if (tick && last_cnt) state_n = ST_DATA;
            ST_DATA:   if (tick && last_cnt) state_n = par_use_q ? ST_PARITY : ST_STOP;
            ST_PARITY: if (tick) state_n = ST_STOP;
            ST_STOP:   if (tick && last_cnt) state_n = load ? ST_START : ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    // Outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txd       <= 1'b1;
            hold_q    <= '0;
            hold_full <= 1'b0;
            shreg     <= '0;
            cnt       <= '0;
            len_q     <= '0;
            par_q     <= 1'b0;
            par_use_q <= 1'b0;
            stop2_q   <= 1'b0;
        end else begin
            if (wr_en) begin
                hold_q    <= wr_data;
                hold_full <= 1'b1;
            end else if (load) begin
                hold_full <= 1'b0;
            end

            if (load) begin
                shreg     <= load_vec;
                len_q     <= data_len(fmt_sel);
                par_q     <= par_calc;
                par_use_q <= par_en && (fmt_sel < 2'd2);
                stop2_q   <= two_stop;
                cnt       <= two_start ? CNT_W'(1) : '0;
                txd       <= 1'b0;
            end else if (tick) begin
                unique case (state)
                    ST_START: begin
                        if (!last_cnt) begin
                            cnt <= cnt - 1'b1;
                            txd <= 1'b0;
                        end else begin
                            txd   <= shreg[0];
                            shreg <= shreg >> 1;
                            cnt   <= len_q - 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (!last_cnt) begin
                            txd   <= shreg[0];
                            shreg <= shreg >> 1;
                            cnt   <= cnt - 1'b1;
                        end else if (par_use_q) begin
                            txd <= par_q;
                        end else begin
                            txd <= 1'b1;
                            cnt <= CNT_W'(stop2_q);
                        end
                    end
                    ST_PARITY: begin
                        txd <= 1'b1;
                        cnt <= CNT_W'(stop2_q);
                    end
                    ST_STOP: begin
                        txd <= 1'b1;
                        if (!last_cnt) cnt <= cnt - 1'b1;
                    end
                    default: txd <= 1'b1;
                endcase
            end
        end
    end

    assign tx_empty = ~hold_full;
    assign tx_busy  = (state != ST_IDLE);
endmodule

// File: rtl/sstx_top.sv
module sstx_top #(
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             bit9,
    input  logic [1:0]       fmt_sel,
    input  logic             par_en,
    input  logic             par_odd,
    input  logic             two_start,
    input  logic             two_stop,
    input  logic             use_int,
    input  logic [DIV_W-1:0] div_val,
    input  logic             sclk_in,
    output logic             sclk_out,
    output logic             sclk_oe,
    output logic             txd,
    output logic             tx_empty,
    output logic             tx_busy
);
    logic int_sclk, int_rise, ext_rise, tick;

    sstx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk      (clk),
        .rst_n    (rst_n),
        .half_div (div_val),
        .sclk     (int_sclk),
        .rise     (int_rise)
    );

    sstx_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sclk_in),
        .rise     (ext_rise)
    );

    assign tick     = use_int ? int_rise : ext_rise;
    assign sclk_out = use_int ? int_sclk : 1'b0;
    assign sclk_oe  = use_int;

    sstx_frame u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .bit9      (bit9),
        .fmt_sel   (fmt_sel),
        .par_en    (par_en),
        .par_odd   (par_odd),
        .two_start (two_start),
        .two_stop  (two_stop),
        .txd       (txd),
        .tx_empty  (tx_empty),
        .tx_busy   (tx_busy)
    );
endmodule

// File: rtl/sstx_checker.sv
module sstx_checker (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic tick,
    input logic txd,
    input logic tx_empty,
    input logic tx_busy
);
    p_line_moves_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(txd));

    p_empty_on_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_empty) |-> tx_busy);

    p_write_fills_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !tx_empty);

    p_busy_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_busy) |-> (tx_empty || $past(wr_en)));

    p_idle_mark_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd);

    p_start_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> !txd);
endmodule

bind sstx_top sstx_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .tick     (tick),
    .txd      (txd),
    .tx_empty (tx_empty),
    .tx_busy  (tx_busy)
);

// File: tb/sim_sstx_top.sv
module sim_sstx_top;
    localparam int DIV_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic bit9 = 1'b0;
    logic [1:0] fmt_sel = 2'd1;
    logic par_en = 1'b0, par_odd = 1'b0, two_start = 1'b0, two_stop = 1'b0;
    logic use_int = 1'b1;
    logic [DIV_W-1:0] div_val = DIV_W'(3);
    logic sclk_in = 1'b0;
    logic sclk_out, sclk_oe, txd, tx_empty, tx_busy;
    logic obs;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    initial begin
        forever begin
            repeat (8) @(posedge clk);
            #1 sclk_in = ~sclk_in;
        end
    end

    assign obs = use_int ? sclk_out : sclk_in;

    sstx_top #(.DIV_W(DIV_W)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .bit9(bit9),
        .fmt_sel(fmt_sel), .par_en(par_en), .par_odd(par_odd), .two_start(two_start),
        .two_stop(two_stop), .use_int(use_int), .div_val(div_val), .sclk_in(sclk_in),
        .sclk_out(sclk_out), .sclk_oe(sclk_oe), .txd(txd), .tx_empty(tx_empty),
        .tx_busy(tx_busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Wait for a rising serial-clock edge, then sample mid-bit
    task automatic wait_bit(output logic b, output logic bz);
        logic prev, cur;
        prev = obs;
        @(negedge clk);
        cur = obs;
        while (!(cur && !prev)) begin
            prev = cur;
            @(negedge clk);
            cur = obs;
        end
        repeat (6) @(negedge clk);
        b  = txd;
        bz = tx_busy;
    endtask

    task automatic mkexp(input logic [7:0] d, output logic [15:0] v, output int n);
        int len;
        logic [8:0] dv;
        logic p;
        len = (fmt_sel == 2'd0) ? 7 : (fmt_sel == 2'd1) ? 8 : 9;
        dv  = (fmt_sel == 2'd0) ? {2'b00, d[6:0]} :
              (fmt_sel == 2'd1) ? {1'b0, d} : {bit9, d};
        p = (^dv) ^ par_odd;
        v = '1;
        n = 0;
        v[n] = 1'b0; n++;
        if (two_start) begin v[n] = 1'b0; n++; end
        for (int i = 0; i < len; i++) begin v[n] = dv[i]; n++; end
        if (par_en && fmt_sel < 2'd2) begin v[n] = p; n++; end
        n++;
        if (two_stop) n++;
    endtask

    task automatic write_byte(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        chk(tx_empty == 1'b0, "R5 empty low after write", tx_empty, 0);
    endtask

    // Capture one frame; optionally write the next byte during it
    task automatic expect_frame(input logic [15:0] v, input int n, input string req,
                                input bit wr2, input logic [7:0] d2, output int gap);
        logic b, bz;
        logic [15:0] got, mask;
        bit busy_ok;
        got = '1;
        gap = 0;
        while (txd && gap < 400) begin
            @(negedge clk);
            gap++;
        end
        repeat (3) @(negedge clk);
        got[0] = txd;
        chk(tx_empty && tx_busy, "R4 empty set and busy at load", {tx_empty, tx_busy}, 3);
        if (wr2) begin
            wr_en = 1'b1;
            wr_data = d2;
            @(negedge clk);
            wr_en = 1'b0;
            chk(tx_empty == 1'b0, "R5 empty low after write during frame", tx_empty, 0);
        end
        busy_ok = 1'b1;
        for (int i = 1; i < n; i++) begin
            wait_bit(b, bz);
            got[i] = b;
            if (!bz) busy_ok = 1'b0;
        end
        mask = 16'((32'h1 << n) - 1);
        chk((got & mask) == (v & mask), req, int'(got & mask), int'(v & mask));
        chk(busy_ok, "R6 busy held through frame", busy_ok, 1);
    endtask

    task automatic single(input logic [7:0] d, input string req);
        logic [15:0] v;
        int n, gap;
        logic b, bz;
        mkexp(d, v, n);
        write_byte(d);
        expect_frame(v, n, req, 1'b0, 8'h00, gap);
        wait_bit(b, bz);
        chk(b == 1'b1 && bz == 1'b0, "R11 R6 line idle at 1, busy low after frame", {b, bz}, 2);
    endtask

    task automatic t_reset;
        chk(txd == 1'b1, "R11 reset line at mark", txd, 1);
        chk(tx_empty == 1'b1, "R4 reset buffer empty", tx_empty, 1);
        chk(tx_busy == 1'b0, "R6 reset not busy", tx_busy, 0);
    endtask

    task automatic t_divider;
        int cnt;
        logic prev;
        chk(sclk_oe == 1'b1, "R12 internal clock enables drive", sclk_oe, 1);
        @(posedge sclk_out);
        @(negedge clk);
        cnt = 0;
        prev = sclk_out;
        while (!(sclk_out && !prev) || cnt == 0) begin
            prev = sclk_out;
            @(negedge clk);
            cnt++;
        end
        chk(cnt == 2 * (int'(div_val) + 1), "R12 divider period", cnt, 2 * (int'(div_val) + 1));
    endtask

    task automatic t_eight;
        fmt_sel = 2'd1; par_en = 1'b0;
        single(8'hA6, "R2 R8 eight-bit frame LSB first");
        single(8'h01, "R1 R2 eight-bit frame single one");
    endtask

    task automatic t_parity;
        fmt_sel = 2'd0; par_en = 1'b1; par_odd = 1'b0;
        single(8'hD3, "R8 R9 seven-bit even parity, bit 7 dropped");
        par_odd = 1'b1;
        single(8'h35, "R9 seven-bit odd parity");
        fmt_sel = 2'd1; par_odd = 1'b0;
        single(8'h7F, "R8 R9 eight-bit even parity");
        par_en = 1'b0;
    endtask

    task automatic t_nine;
        fmt_sel = 2'd2; par_en = 1'b1; bit9 = 1'b1;
        single(8'h5A, "R7 nine-bit address bit set, parity suppressed");
        bit9 = 1'b0; fmt_sel = 2'd3;
        single(8'hC3, "R7 nine-bit data bit clear");
        par_en = 1'b0; fmt_sel = 2'd1;
    endtask

    task automatic t_two;
        two_start = 1'b1; two_stop = 1'b1;
        single(8'h96, "R10 two start and two stop bits");
        two_start = 1'b0;
        fmt_sel = 2'd0; par_en = 1'b1;
        single(8'h4B, "R10 one start, parity, two stop bits");
        two_stop = 1'b0; par_en = 1'b0; fmt_sel = 2'd1;
    endtask

    task automatic t_back2back;
        logic [15:0] va, vb;
        int na, nb, gap;
        logic b, bz;
        mkexp(8'h3C, va, na);
        mkexp(8'hE1, vb, nb);
        write_byte(8'h3C);
        expect_frame(va, na, "R3 first of back-to-back frames", 1'b1, 8'hE1, gap);
        expect_frame(vb, nb, "R3 second frame data", 1'b0, 8'h00, gap);
        chk(gap <= 8, "R3 no idle bit between frames", gap, 8);
        wait_bit(b, bz);
        chk(b == 1'b1 && bz == 1'b0, "R6 busy drops after second frame", {b, bz}, 2);
    endtask

    task automatic t_external;
        repeat (4) @(negedge clk);
        use_int = 1'b0;
        @(negedge clk);
        chk(sclk_oe == 1'b0 && sclk_out == 1'b0, "R12 external clock, no drive", {sclk_oe, sclk_out}, 0);
        single(8'h9D, "R12 R2 frame on external clock");
        use_int = 1'b1;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_divider;
        t_eight;
        t_parity;
        t_nine;
        t_two;
        t_back2back;
        t_external;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired: actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule